// File: doc/BRIEF.md
# Tile Engine Interrupt Controller with Overflow Pool Re-arm

This block gathers the interrupt causes of one core of a tile-based graphics engine into a sticky status register and drives a single level interrupt line toward the host. There are four causes. The binner can ask for more overflow memory. The binning pass and the rendering pass each report a flush-done event. The memory protection logic reports a violation. Software reads the status word and acknowledges causes by writing ones to a clear register. Sources are masked and unmasked through two separate registers, one that sets mask bits and one that clears them. The interrupt line is high whenever a status bit is set and its mask bit is not.

The request for more binner memory is edge sensitive and fires only once. The binner may raise the request before its pool is fully used, so the current job can still finish without more memory. After the cause fires, no further request is recorded until software supplies a new overflow pool. Software does this by writing the pool page number and then the pool byte count. Writing the byte count re-arms the detector. A strobe from the binner reports that it has taken the pool, and the stored byte count then drops to zero. At start-up, software writes the full cause set to the clear register to drop stale events. To shut the block down, it writes all ones to the mask-set register and then clears the causes.

Top module: `irq_ctl_core`

## Requirements
- R1: After reset the status reads 0, the mask reads 0xF (all four sources masked), the interrupt is low, the pool page and pool size read 0, and the memory-request detector is armed.
- R2: A one-cycle pulse on bin_done_i, rnd_done_i or prot_viol_i sets status bit 1, 2 or 3 respectively, and the bit stays set until it is cleared.
- R3: A write to the clear register (address 1) clears exactly those status bits that are one in the written word and keeps all other bits.
- R4: When a cause event and a clear of the same bit land in the same cycle, the bit stays set.
- R5: A write to mask-set (address 3) sets the mask bits that are one in the word. A write to mask-clear (address 4) clears them. The mask reads back at address 2.
- R6: irq_o is high exactly when some status bit is set while its mask bit is clear. It follows the status register with no added register stage.
- R7: A rising edge on oom_req_i while the detector is armed sets status bit 0 and disarms the detector. Holding oom_req_i high records only one event.
- R8: While the detector is disarmed, further rising edges on oom_req_i set no status bit, even after bit 0 has been cleared.
- R9: A write to the pool size register (address 6) re-arms the detector, and the next rising edge sets bit 0 again. A write to the pool page register (address 5) does not re-arm it.
- R10: The pool page (address 5, PAGE_W bits) and the pool size (address 6, bytes) read back as written. A pulse on pool_take_i sets the size to 0 and leaves the page unchanged.
- R11: A read (bus_sel_i high, bus_wr_i low) returns its data on bus_rdata_o one cycle later. Address 0 returns the status in bits 3:0. Address 1, address 4 and address 7 read 0.
- R12: Bits above bit 3 in words written to the clear, mask-set and mask-clear registers are ignored, and the mask reads back in bits 3:0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| oom_req_i | input | 1 | Binner memory request level, edge detected |
| bin_done_i | input | 1 | Bin flush done pulse |
| rnd_done_i | input | 1 | Render flush done pulse |
| prot_viol_i | input | 1 | Protection violation pulse |
| pool_take_i | input | 1 | Binner has taken the overflow pool |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The assertions assume one register access per cycle. They therefore never see mask-set and mask-clear, or a size write and a page write, in the same cycle. They also assume every input is settled and free of X after reset is released. The bench drives all inputs on the falling edge and issues only single accesses, so it keeps within these assumptions. It also places an event and a clear of the same bit in one cycle on purpose, because the status assertions treat that case as legal.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NSRC   = 4;
    localparam int ADDR_W = 3;

    localparam int SRC_OOM  = 0;
    localparam int SRC_BIN  = 1;
    localparam int SRC_RND  = 2;
    localparam int SRC_PROT = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS = 3'd0,
        RA_ACK    = 3'd1,
        RA_MASK   = 3'd2,
        RA_MSET   = 3'd3,
        RA_MCLR   = 3'd4,
        RA_PAGE   = 3'd5,
        RA_SIZE   = 3'd6,
        RA_NONE   = 3'd7
    } reg_addr_e;

    typedef logic [NSRC-1:0] src_vec_t;

endpackage

// File: rtl/irq_ctl_oom_arm.sv
module irq_ctl_oom_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic rearm_i,
    output logic fire_o
);

    typedef struct packed {
        logic prev;
        logic armed;
    } arm_state_t;

    arm_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d      = st_q;
        rise      = req_i & ~st_q.prev;
        fire_o    = rise & st_q.armed;
        st_d.prev = req_i;
        if (rearm_i) begin
            st_d.armed = 1'b1;
        end else if (fire_o) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b0, armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    AST_OOM_STAYS_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !rearm_i) |=> !st_q.armed); // R8

    AST_OOM_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> st_q.armed); // R9

    AST_OOM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o); // R7

endmodule

// File: rtl/irq_ctl_status.sv
module irq_ctl_status #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_en_i,
    input  logic [NSRC-1:0] clr_bits_i,
    output logic [NSRC-1:0] status_o
);

    typedef struct packed {
        logic [NSRC-1:0] bits;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [NSRC-1:0] drop;

    always_comb begin
        st_d = st_q;
        drop = clr_en_i ? clr_bits_i : '0;
        for (int i = 0; i < NSRC; i++) begin
            if (set_i[i]) begin
                st_d.bits[i] = 1'b1;
            end else if (drop[i]) begin
                st_d.bits[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.bits;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R2

    AST_CLR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((status_o & $past(clr_bits_i & ~set_i)) == '0)); // R3

    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((status_o & $past(status_o & ~clr_bits_i))
                      == $past(status_o & ~clr_bits_i))); // R3

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && ((set_i & clr_bits_i) != '0))
        |=> ((status_o & $past(set_i & clr_bits_i)) == $past(set_i & clr_bits_i))); // R4

endmodule

// File: rtl/irq_ctl_mask.sv
module irq_ctl_mask #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en_i,
    input  logic            clr_en_i,
    input  logic [NSRC-1:0] bits_i,
    output logic [NSRC-1:0] mask_o
);

    typedef struct packed {
        logic [NSRC-1:0] bits;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en_i) begin
            st_d.bits = st_q.bits | bits_i;
        end else if (clr_en_i) begin
            st_d.bits = st_q.bits & ~bits_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bits: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.bits;

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((mask_o & $past(bits_i)) == $past(bits_i))); // R5

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !set_en_i) |=> ((mask_o & $past(bits_i)) == '0)); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(mask_o)); // R5

endmodule

// File: rtl/irq_ctl_pool.sv
module irq_ctl_pool #(
    parameter int PAGE_W = 20,
    parameter int SIZE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_wr_i,
    input  logic              size_wr_i,
    input  logic              take_i,
    input  logic [PAGE_W-1:0] page_wdata_i,
    input  logic [SIZE_W-1:0] size_wdata_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [SIZE_W-1:0] size_o
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SIZE_W-1:0] size;
    } pool_state_t;

    pool_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (page_wr_i) begin
            st_d.page = page_wdata_i;
        end
        if (size_wr_i) begin
            st_d.size = size_wdata_i;
        end else if (take_i) begin
            st_d.size = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_o = st_q.page;
    assign size_o = st_q.size;

    AST_POOL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !size_wr_i) |=> (size_o == '0)); // R10

    AST_POOL_SIZE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        size_wr_i |=> (size_o == $past(size_wdata_i))); // R10

    AST_POOL_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !page_wr_i |=> $stable(page_o)); // R10

endmodule

// File: rtl/irq_ctl_core.sv
module irq_ctl_core
    import irq_ctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              oom_req_i,
    input  logic              bin_done_i,
    input  logic              rnd_done_i,
    input  logic              prot_viol_i,
    input  logic              pool_take_i,
    output logic              irq_o
);

    localparam int SIZE_W = DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    bus_state_t bst_d, bst_q;

    reg_addr_e   addr;
    logic        wr_ack, wr_mset, wr_mclr, wr_page, wr_size, rd_en;
    logic        oom_fire;
    src_vec_t    events;
    src_vec_t    status;
    src_vec_t    mask;
    logic [PAGE_W-1:0] pool_page;
    logic [SIZE_W-1:0] pool_size;

    always_comb begin
        addr    = reg_addr_e'(bus_addr_i);
        rd_en   = bus_sel_i & ~bus_wr_i;
        wr_ack  = bus_sel_i & bus_wr_i & (addr == RA_ACK);
        wr_mset = bus_sel_i & bus_wr_i & (addr == RA_MSET);
        wr_mclr = bus_sel_i & bus_wr_i & (addr == RA_MCLR);
        wr_page = bus_sel_i & bus_wr_i & (addr == RA_PAGE);
        wr_size = bus_sel_i & bus_wr_i & (addr == RA_SIZE);
    end

    always_comb begin
        events           = '0;
        events[SRC_OOM]  = oom_fire;
        events[SRC_BIN]  = bin_done_i;
        events[SRC_RND]  = rnd_done_i;
        events[SRC_PROT] = prot_viol_i;
    end

    irq_ctl_oom_arm u_oom (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (oom_req_i),
        .rearm_i (wr_size),
        .fire_o  (oom_fire)
    );

    irq_ctl_status #(.NSRC(NSRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (events),
        .clr_en_i   (wr_ack),
        .clr_bits_i (bus_wdata_i[NSRC-1:0]),
        .status_o   (status)
    );

    irq_ctl_mask #(.NSRC(NSRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (wr_mset),
        .clr_en_i (wr_mclr),
        .bits_i   (bus_wdata_i[NSRC-1:0]),
        .mask_o   (mask)
    );

    irq_ctl_pool #(.PAGE_W(PAGE_W), .SIZE_W(SIZE_W)) u_pool (
        .clk          (clk),
        .rst_n        (rst_n),
        .page_wr_i    (wr_page),
        .size_wr_i    (wr_size),
        .take_i       (pool_take_i),
        .page_wdata_i (bus_wdata_i[PAGE_W-1:0]),
        .size_wdata_i (bus_wdata_i[SIZE_W-1:0]),
        .page_o       (pool_page),
        .size_o       (pool_size)
    );

    always_comb begin
        bst_d = bst_q;
        if (rd_en) begin
            case (addr)
                RA_STATUS: bst_d.rdata = DATA_W'(status);
                RA_MASK:   bst_d.rdata = DATA_W'(mask);
                RA_PAGE:   bst_d.rdata = DATA_W'(pool_page);
                RA_SIZE:   bst_d.rdata = DATA_W'(pool_size);
                default:   bst_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bst_q <= '0;
        end else begin
            bst_q <= bst_d;
        end
    end

    assign bus_rdata_o = bst_q.rdata;
    assign irq_o       = |(status & ~mask);

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_o); // R6

    AST_RD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RA_STATUS) |=> (bus_rdata_o == DATA_W'($past(status)))); // R11

    AST_RD_WRONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == RA_ACK || addr == RA_MCLR)) |=> (bus_rdata_o == '0)); // R11

endmodule

// File: tb/irq_ctl_core_bench.sv
`timescale 1ns/1ps
module irq_ctl_core_bench;

    localparam int DATA_W = 32;

    typedef struct packed {
        logic [1:0]  op;    // 0 idle, 1 write, 2 read
        logic [2:0]  addr;
        logic [31:0] data;
        logic [3:0]  ev;    // [0] oom level, [1] bin, [2] rnd, [3] prot
        logic        irq;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 3'd4, 32'h0000_000F, 4'h0, 1'b0, 32'h0},          // 0 unmask all R5
        '{2'd0, 3'd0, 32'h0,         4'h2, 1'b1, 32'h0},          // 1 bin R2 R6
        '{2'd2, 3'd0, 32'h0,         4'h0, 1'b1, 32'h2},          // 2 R11
        '{2'd0, 3'd0, 32'h0,         4'hC, 1'b1, 32'h0},          // 3 rnd+prot R2
        '{2'd2, 3'd0, 32'h0,         4'h0, 1'b1, 32'hE},          // 4 R2
        '{2'd1, 3'd1, 32'h0000_0004, 4'h0, 1'b1, 32'h0},          // 5 clear bit2 R3
        '{2'd2, 3'd0, 32'h0,         4'h0, 1'b1, 32'hA},          // 6 R3
        '{2'd1, 3'd3, 32'h0000_000A, 4'h0, 1'b0, 32'h0},          // 7 mask set R5 R6
        '{2'd2, 3'd2, 32'h0,         4'h0, 1'b0, 32'hA},          // 8 R5
        '{2'd1, 3'd4, 32'h0000_0008, 4'h0, 1'b1, 32'h0},          // 9 mask clr R5 R6
        '{2'd1, 3'd1, 32'hFFFF_FFFF, 4'h0, 1'b0, 32'h0},          // 10 clear all R3
        '{2'd2, 3'd0, 32'h0,         4'h0, 1'b0, 32'h0},          // 11 R3
        '{2'd0, 3'd0, 32'h0,         4'h1, 1'b1, 32'h0},          // 12 oom edge R7
        '{2'd0, 3'd0, 32'h0,         4'h1, 1'b1, 32'h0},          // 13 held R7
        '{2'd1, 3'd1, 32'h0000_0001, 4'h1, 1'b0, 32'h0},          // 14 clear, held R7
        '{2'd0, 3'd0, 32'h0,         4'h0, 1'b0, 32'h0},          // 15
        '{2'd0, 3'd0, 32'h0,         4'h1, 1'b0, 32'h0},          // 16 disarmed R8
        '{2'd2, 3'd0, 32'h0,         4'h1, 1'b0, 32'h0},          // 17 R8
        '{2'd0, 3'd0, 32'h0,         4'h0, 1'b0, 32'h0},          // 18
        '{2'd1, 3'd5, 32'h0000_0123, 4'h0, 1'b0, 32'h0},          // 19 page write R9
        '{2'd0, 3'd0, 32'h0,         4'h1, 1'b0, 32'h0},          // 20 still disarmed R9
        '{2'd0, 3'd0, 32'h0,         4'h0, 1'b0, 32'h0},          // 21
        '{2'd1, 3'd6, 32'h0004_0000, 4'h0, 1'b0, 32'h0},          // 22 size write R9
        '{2'd2, 3'd6, 32'h0,         4'h0, 1'b0, 32'h0004_0000},  // 23 R10
        '{2'd2, 3'd5, 32'h0,         4'h0, 1'b0, 32'h0000_0123},  // 24 R10
        '{2'd0, 3'd0, 32'h0,         4'h1, 1'b1, 32'h0},          // 25 re-armed R9
        '{2'd2, 3'd0, 32'h0,         4'h0, 1'b1, 32'h1},          // 26 R9
        '{2'd1, 3'd1, 32'h0000_0001, 4'h0, 1'b0, 32'h0},          // 27 R3
        '{2'd2, 3'd1, 32'h0,         4'h0, 1'b0, 32'h0},          // 28 write-only reads 0 R11
        '{2'd1, 3'd3, 32'hFFFF_FFF0, 4'h0, 1'b0, 32'h0},          // 29 upper bits R12
        '{2'd2, 3'd2, 32'h0,         4'h0, 1'b0, 32'h2}           // 30 mask unchanged R12
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              oom_req = 1'b0;
    logic              bin_done = 1'b0;
    logic              rnd_done = 1'b0;
    logic              prot_viol = 1'b0;
    logic              pool_take = 1'b0;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctl_core u_irq_ctl_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .oom_req_i   (oom_req),
        .bin_done_i  (bin_done),
        .rnd_done_i  (rnd_done),
        .prot_viol_i (prot_viol),
        .pool_take_i (pool_take),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        bin_done = 1'b0; rnd_done = 1'b0; prot_viol = 1'b0; pool_take = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        idle_inputs();
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        do_read(3'd0, rd); check("R1 status", rd, 32'h0);
        do_read(3'd2, rd); check("R1 mask", rd, 32'hF);
        do_read(3'd5, rd); check("R1 page", rd, 32'h0);
        do_read(3'd6, rd); check("R1 size", rd, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            bus_sel   = (VEC[i].op != 2'd0);
            bus_wr    = (VEC[i].op == 2'd1);
            bus_addr  = VEC[i].addr;
            bus_wdata = VEC[i].data;
            oom_req   = VEC[i].ev[0];
            bin_done  = VEC[i].ev[1];
            rnd_done  = VEC[i].ev[2];
            prot_viol = VEC[i].ev[3];
            @(negedge clk);
            check($sformatf("vec %0d irq R6", i), {31'b0, irq}, {31'b0, VEC[i].irq});
            if (VEC[i].op == 2'd2)
                check($sformatf("vec %0d rdata R11", i), bus_rdata, VEC[i].exp);
            idle_inputs();
        end
        oom_req = 1'b0;
        @(negedge clk);

        // R4 event and clear of the same bit in one cycle
        do_write(3'd4, 32'hF);
        rnd_done = 1'b1;
        do_write(3'd1, 32'h4);
        check("R4 irq", {31'b0, irq}, 32'h1);
        do_read(3'd0, rd); check("R4 status", rd, 32'h4);
        do_write(3'd1, 32'hF);
        check("R3 irq after clear", {31'b0, irq}, 32'h0);

        // R10 pool take zeroes size, keeps page
        pool_take = 1'b1;
        @(negedge clk);
        pool_take = 1'b0;
        do_read(3'd6, rd); check("R10 size after take", rd, 32'h0);
        do_read(3'd5, rd); check("R10 page after take", rd, 32'h123);

        // R11 unused address reads zero
        do_read(3'd7, rd); check("R11 addr7", rd, 32'h0);

        // R12 upper bits on mask-clear ignored; mask was 0xF
        do_write(3'd3, 32'hF);
        do_write(3'd4, 32'hFFFF_FFF0);
        do_read(3'd2, rd); check("R12 mask clr upper", rd, 32'hF);

        // R5 R6: masked pending event keeps irq low, unmask raises it
        prot_viol = 1'b1;
        @(negedge clk);
        prot_viol = 1'b0;
        check("R6 masked pending", {31'b0, irq}, 32'h0);
        do_write(3'd4, 32'h8);
        check("R6 unmasked pending", {31'b0, irq}, 32'h1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule